// File: doc/BRIEF.md
# Vectored Interrupt Controller with Shared Peripheral Vector

This block is the interrupt unit of a small microcontroller core. Eleven event inputs each set a sticky flag bit, and every flag has its own enable bit. Three sources have their own vectors: the external pin, timer 0 overflow and the timer 0 clock-input edge. The other eight sources are peripherals. They are also gated by a peripheral group enable, and they share a fourth vector. A global disable bit blocks every request to the core. A wake-up output is still driven whenever an enabled request is pending, so a sleeping core can resume.

When the core accepts a request, the block sets the global disable bit, strobes a push of the return address and presents a two-bit vector index that the core turns into an address. An entry through a dedicated vector clears that source's flag. An entry through the shared vector leaves the peripheral flags alone, and software must clear them. A return-from-interrupt input strobes a stack pop and clears the global disable bit. Software reads and writes the flags, the enables and the control bits through a small register port.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset all flags and enables read 0, the control register reads 2'b01 (global disable set, group enable clear), and no request or wake-up is driven.
- R2: A high event bit sets its flag at the next edge, whatever the enable bits or the global disable bit are. Flag bit positions are: 0 external pin, 1 timer 0 overflow, 2 timer 0 clock edge, 3 timer 1, 4 timer 2, 5 timer 3, 6 capture 1, 7 capture 2, 8 transmit empty, 9 receive full, 10 port change.
- R3: The register port decodes three addresses. Address 0 holds the flags and address 1 the enables, both using the R2 bit positions. Address 2 is control, with bit 0 the global disable and bit 1 the peripheral group enable. A write replaces the addressed register, and address 3 reads 0.
- R4: The request is high when at least one vector is pending and the global disable bit is clear. A dedicated vector is pending when its flag and enable are both set. The shared vector is pending when any peripheral flag with its enable set exists and the group enable is set.
- R5: Accepting a request (ack high while the request is high) drives the push strobe in the same cycle and sets the global disable bit at the next edge.
- R6: Accepting through a dedicated vector clears that source's flag at the next edge.
- R7: Accepting through the shared vector leaves every peripheral flag unchanged, so the request returns after a return-from-interrupt unless software clears the flag.
- R8: A return-from-interrupt input drives the pop strobe in the same cycle and clears the global disable bit at the next edge.
- R9: The vector index follows a fixed priority: 0 external pin, then 1 timer 0 overflow, then 2 timer 0 clock edge, then 3 shared peripheral.
- R10: Wake-up is high whenever any vector is pending, whatever the global disable bit is.
- R11: An event and a software write of 0 to the same flag in the same cycle leave the flag set.
- R12: An event and an automatic clear of the same dedicated flag in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 11 | Event pulses, one bit per source |
| reg_addr_i | input | 2 | Register port address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 11 | Register write data |
| reg_rdata_o | output | 11 | Register read data (combinational) |
| ack_i | input | 1 | Core accepts the pending request |
| reti_i | input | 1 | Core executes return-from-interrupt |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 2 | Vector index of the request |
| push_o | output | 1 | Return-address push strobe |
| pop_o | output | 1 | Stack pop strobe |
| wake_o | output | 1 | Wake-up from sleep |

## Verification
A flag has three writers, and the collisions between them are where it can fail. A hardware event can land in the same cycle as a software write of 0 to that flag. It can also land in the same cycle as the automatic clear made when its dedicated vector is accepted. The bench causes both collisions. For the first it raises the event bit during a flag-register write. For the second it raises the event bit of the external pin in the same cycle as the ack for that vector. It then reads the flag register, and for the auto-clear case it also checks that the request comes back after return-from-interrupt.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC = 11;
  localparam int NUM_DED = 3;
  localparam int NUM_VEC = NUM_DED + 1;
  localparam int VEC_W   = $clog2(NUM_VEC);

  typedef enum logic [VEC_W-1:0] {
    VEC_EXT    = 2'd0,
    VEC_TMR0   = 2'd1,
    VEC_T0EDGE = 2'd2,
    VEC_PERIPH = 2'd3
  } vec_e;

  // Combined peripheral request, gated by the group enable
  function automatic logic periph_pending(input logic [NUM_SRC-1:0] f,
                                          input logic [NUM_SRC-1:0] e,
                                          input logic grp);
    return grp & (|(f[NUM_SRC-1:NUM_DED] & e[NUM_SRC-1:NUM_DED]));
  endfunction

  // Keep only the lowest set bit (highest priority)
  function automatic logic [NUM_VEC-1:0] first_grant(input logic [NUM_VEC-1:0] p);
    return p & (~p + 1'b1);
  endfunction

  function automatic logic [VEC_W-1:0] grant_index(input logic [NUM_VEC-1:0] g);
    logic [VEC_W-1:0] idx;
    idx = '0;
    for (int k = 0; k < NUM_VEC; k++)
      if (g[k]) idx = k[VEC_W-1:0];
    return idx;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               flag_wr_i,
  input  logic               en_wr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic               auto_clr_i,
  input  logic [VEC_W-1:0]   clr_idx_i,
  output logic [NUM_SRC-1:0] flags_o,
  output logic [NUM_SRC-1:0] enables_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       enables_o <= '0;
    else if (en_wr_i) enables_o <= wdata_i;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    logic clr_hit;
    logic nxt;
    if (i < NUM_DED) begin : g_ded
      assign clr_hit = auto_clr_i && (clr_idx_i == i[VEC_W-1:0]);
    end else begin : g_per
      assign clr_hit = 1'b0;
    end
    // event has the last word so no event is lost
    assign nxt = ((flag_wr_i ? wdata_i[i] : flags_o[i]) & ~clr_hit) | evt_i[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_o[i] <= 1'b0;
      else        flags_o[i] <= nxt;
    end

    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[i] |=> flags_o[i]); // R2
    AST_EVT_OVER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i[i] && flag_wr_i && !wdata_i[i]) |=> flags_o[i]); // R11
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] flags_i,
  input  logic [NUM_SRC-1:0] enables_i,
  input  logic               grp_en_i,
  input  logic               gdis_i,
  output logic [NUM_VEC-1:0] grant_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               req_o,
  output logic               wake_o
);
  logic [NUM_VEC-1:0] pend;

  always_comb begin
    pend[NUM_DED-1:0] = flags_i[NUM_DED-1:0] & enables_i[NUM_DED-1:0];
    pend[NUM_VEC-1]   = periph_pending(flags_i, enables_i, grp_en_i);
  end

  assign grant_o = first_grant(pend);
  assign vec_o   = grant_index(grant_o);
  assign wake_o  = |pend;
  assign req_o   = (|pend) & ~gdis_i;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R9
  AST_PERIPH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o[NUM_VEC-1] |-> (pend[NUM_DED-1:0] == '0)); // R9
  AST_REQ_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> wake_o); // R10
endmodule

// File: rtl/irq_core_ctl.sv
module irq_core_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr_i,
  input  logic gdis_wdata_i,
  input  logic grp_wdata_i,
  input  logic req_i,
  input  logic ack_i,
  input  logic reti_i,
  output logic gdis_o,
  output logic grp_en_o,
  output logic take_o,
  output logic push_o,
  output logic pop_o
);
  assign take_o = req_i & ack_i;
  assign push_o = take_o;
  assign pop_o  = reti_i;

  // priority: accept > return > software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gdis_o <= 1'b1;
    else if (take_o)    gdis_o <= 1'b1;
    else if (reti_i)    gdis_o <= 1'b0;
    else if (ctrl_wr_i) gdis_o <= gdis_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         grp_en_o <= 1'b0;
    else if (ctrl_wr_i) grp_en_o <= grp_wdata_i;
  end

  AST_TAKE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> gdis_o); // R5
  AST_RETI_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !take_o) |=> !gdis_o); // R8
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic               reg_wr_i,
  input  logic [NUM_SRC-1:0] reg_wdata_i,
  output logic [NUM_SRC-1:0] reg_rdata_o,
  input  logic               ack_i,
  input  logic               reti_i,
  output logic               irq_req_o,
  output logic [VEC_W-1:0]   irq_vec_o,
  output logic               push_o,
  output logic               pop_o,
  output logic               wake_o
);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2);

  logic [NUM_SRC-1:0] flags_q, enables_q;
  logic [NUM_VEC-1:0] grant;
  logic gdis_q, grp_en_q, take;
  logic flag_wr, en_wr, ctrl_wr;

  assign flag_wr = reg_wr_i && (reg_addr_i == A_FLAG);
  assign en_wr   = reg_wr_i && (reg_addr_i == A_EN);
  assign ctrl_wr = reg_wr_i && (reg_addr_i == A_CTRL);

  irq_flag_bank u_bank (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .flag_wr_i(flag_wr), .en_wr_i(en_wr), .wdata_i(reg_wdata_i),
    .auto_clr_i(take && (irq_vec_o != VEC_PERIPH)), .clr_idx_i(irq_vec_o),
    .flags_o(flags_q), .enables_o(enables_q)
  );

  irq_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .flags_i(flags_q), .enables_i(enables_q),
    .grp_en_i(grp_en_q), .gdis_i(gdis_q), .grant_o(grant),
    .vec_o(irq_vec_o), .req_o(irq_req_o), .wake_o(wake_o)
  );

  irq_core_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr_i(ctrl_wr),
    .gdis_wdata_i(reg_wdata_i[0]), .grp_wdata_i(reg_wdata_i[1]),
    .req_i(irq_req_o), .ack_i(ack_i), .reti_i(reti_i),
    .gdis_o(gdis_q), .grp_en_o(grp_en_q), .take_o(take),
    .push_o(push_o), .pop_o(pop_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      A_FLAG:  reg_rdata_o = flags_q;
      A_EN:    reg_rdata_o = enables_q;
      A_CTRL:  reg_rdata_o = {{(NUM_SRC-2){1'b0}}, grp_en_q, gdis_q};
      default: reg_rdata_o = '0;
    endcase
  end

  AST_DED_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (take && irq_vec_o != VEC_PERIPH && !evt_i[irq_vec_o])
      |=> !flags_q[$past(irq_vec_o)]); // R6
  AST_PERIPH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && irq_vec_o == VEC_PERIPH && !flag_wr)
      |=> (($past(flags_q) & ~flags_q) == '0)); // R7
  AST_PUSH_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> (irq_req_o && ack_i && $onehot(grant))); // R5
  AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (take && irq_vec_o != VEC_PERIPH && evt_i[irq_vec_o])
      |=> flags_q[$past(irq_vec_o)]); // R12
endmodule

// File: tb/irq_vector_ctrl_test.sv
`timescale 1ns/1ps
module irq_vector_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] evt = '0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0;
  logic [10:0] wdata = '0;
  logic [10:0] rdata;
  logic        ack = 1'b0, reti = 1'b0;
  logic        req, push, pop, wake;
  logic [1:0]  vec;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ack_i(ack), .reti_i(reti),
    .irq_req_o(req), .irq_vec_o(vec), .push_o(push), .pop_o(pop), .wake_o(wake)
  );

  // flags[27:17] en[16:6] ctrl[5:4] req[3] wake[2] vec[1:0]
  localparam logic [27:0] TBL [9] = '{
    {11'h001, 11'h001, 2'b00, 1'b1, 1'b1, 2'd0},
    {11'h007, 11'h006, 2'b00, 1'b1, 1'b1, 2'd1},
    {11'h004, 11'h004, 2'b01, 1'b0, 1'b1, 2'd0},
    {11'h008, 11'h008, 2'b00, 1'b0, 1'b0, 2'd0},
    {11'h008, 11'h008, 2'b10, 1'b1, 1'b1, 2'd3},
    {11'h404, 11'h400, 2'b10, 1'b1, 1'b1, 2'd3},
    {11'h7FF, 11'h000, 2'b10, 1'b0, 1'b0, 2'd0},
    {11'h00C, 11'h00C, 2'b10, 1'b1, 1'b1, 2'd2},
    {11'h000, 11'h7FF, 2'b10, 1'b0, 1'b0, 2'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [10:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick();
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [10:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic pulse(input logic [10:0] e);
    evt = e; tick(); evt = '0; #0.5;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [10:0] d;
    repeat (3) tick();
    #0.5;
    // R1 reset state
    rreg(0, d); chk("R1 flags", d, 0);
    rreg(1, d); chk("R1 enables", d, 0);
    rreg(2, d); chk("R1 ctrl", d, 11'h001);
    chk("R1 req", req, 0); chk("R1 wake", wake, 0);
    rst_n = 1'b1;
    tick();

    // R4 R9 R10 R3 table
    foreach (TBL[k]) begin
      wreg(0, TBL[k][27:17]);
      wreg(1, TBL[k][16:6]);
      wreg(2, {9'd0, TBL[k][5:4]});
      rreg(0, d);
      chk("R3 flag readback", d, TBL[k][27:17]);
      chk("R4 req", req, TBL[k][3]);
      chk("R10 wake", wake, TBL[k][2]);
      if (TBL[k][3]) chk("R9 vec", vec, TBL[k][1:0]);
    end
    rreg(3, d); chk("R3 addr3 zero", d, 0);

    // R5 R6 dedicated entry
    wreg(0, 0); wreg(1, 11'h7FF); wreg(2, 11'h002);
    pulse(11'h002);
    chk("R6 req", req, 1); chk("R9 vec tmr0", vec, 1);
    ack = 1'b1; #0.5;
    chk("R5 push", push, 1);
    tick(); ack = 1'b0; #0.5;
    chk("R5 req after take", req, 0);
    rreg(2, d); chk("R5 gdis set", d, 11'h003);
    rreg(0, d); chk("R6 flag cleared", d, 0);
    // R8 return
    reti = 1'b1; #0.5;
    chk("R8 pop", pop, 1);
    tick(); reti = 1'b0;
    rreg(2, d); chk("R8 gdis clear", d, 11'h002);

    // R7 shared vector
    pulse(11'h100);
    chk("R7 vec", vec, 3);
    ack = 1'b1; tick(); ack = 1'b0;
    rreg(0, d); chk("R7 flag kept", d, 11'h100);
    chk("R7 req masked", req, 0);
    reti = 1'b1; tick(); reti = 1'b0; #0.5;
    chk("R7 req again", req, 1); chk("R7 vec again", vec, 3);
    wreg(0, 0);
    chk("R7 cleared by sw", req, 0);

    // R12 event collides with auto-clear
    pulse(11'h001);
    chk("R12 vec", vec, 0);
    ack = 1'b1; evt = 11'h001; tick(); ack = 1'b0; evt = '0;
    rreg(0, d); chk("R12 flag stays", d, 11'h001);
    rreg(2, d); chk("R12 gdis", d, 11'h003);
    reti = 1'b1; tick(); reti = 1'b0; #0.5;
    chk("R12 req returns", req, 1);
    wreg(0, 0);

    // R11 event collides with software clear
    wreg(0, 11'h010);
    addr = 0; wdata = 0; wr = 1'b1; evt = 11'h010;
    tick(); wr = 1'b0; evt = '0;
    rreg(0, d); chk("R11 flag stays", d, 11'h010);
    wreg(0, 0);

    // R2 event with everything masked
    wreg(2, 11'h001); wreg(1, 0);
    pulse(11'h020);
    rreg(0, d); chk("R2 flag set masked", d, 11'h020);
    chk("R2 req", req, 0); chk("R2 wake", wake, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule